// File: doc/BRIEF.md
# Hot-Swap Power-Path Mode Sequencer

This block is the digital controller of a hot-swap power path. It decides when the external pass switch may turn on, and it tracks the controller through seven operating modes. The gate driver, the charge pump, the comparators, the strobed supply monitor and the overcurrent timer are outside the block. Each of them reaches the sequencer as a single digital flag.

The block starts only when the enable is asserted and the supply is above its lockout level. A debounce period, measured in 1 ms ticks, must then pass while the strobed monitor reports no voltage fault. After that the gate ramps. The status output goes high once the gate reaches its high threshold. It stays latched until a shutdown, a lockout, a voltage fault or a current fault. Overcurrent is tracked as its own mode. When the overcurrent timer fills, the current-fault latch sets. A build parameter chooses what happens next: latch-off, where only a long enable-low pulse, a lockout or a voltage fault clears the latch, or auto-retry, where a timed wait restarts the ramp.

Top module: `hotswap_seq`

## Requirements
- R1: On synchronous reset the outputs are mode = shutdown, gate_ramp = 0, gate_pd = 1, status_ok = 0 and low_pwr = 1.
- R2: `mode` is always one-hot with these bit positions: 0 shutdown, 1 debounce, 2 start-up, 3 normal-on, 4 overcurrent, 5 current fault, 6 voltage fault.
- R3: From shutdown, an enabled supply that is not locked out enters debounce. Start-up is entered on the DEBOUNCE_MS-th tick that debounce counts.
- R4: A voltage fault during debounce clears the debounce count. With the gate low, the block enters voltage-fault mode and returns to debounce only when the fault flag clears. The count then starts again from zero.
- R5: status_ok rises when the gate-high flag is seen in start-up, which moves the mode to normal-on. It stays high through overcurrent entered from normal-on and stays low in overcurrent entered from start-up. It is cleared by any turn-off event and does not come back without a new start-up.
- R6: Enable low, lockout or a voltage fault drops gate_ramp (and raises gate_pd) one cycle after the condition is seen. While the gate-low flag is clear the mode drains in debounce. Shutdown or voltage-fault mode is entered only when the gate-low flag is set.
- R7: The breaker flag in start-up or normal-on enters overcurrent. When the flag clears, the mode returns to normal-on if status was latched, and to start-up otherwise.
- R8: The timer-full flag in start-up, normal-on or overcurrent enters current-fault mode with gate_ramp = 0 and status_ok = 0.
- R9: In latch-off builds, current-fault mode is held until the synchronized enable has been low for EN_LOW_CLKS clocks, the supply is locked out, or a voltage fault arrives (each is acted on once the gate is low). A shorter enable-low pulse leaves the latch set.
- R10: In auto-retry builds, the block counts RETRY_MS ticks in current-fault mode while the timer-empty flag is set, then re-enters start-up.
- R11: low_pwr is 0 exactly in start-up, in overcurrent, and in current-fault mode while the timer is not yet empty.
- R12: en_in and uvlo_in pass through two flip-flops. A change on either is reflected in the mode three clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| en_in | input | 1 | Asynchronous enable request |
| uvlo_in | input | 1 | Asynchronous supply lockout flag (1 = locked out) |
| vflt_in | input | 1 | Latched voltage fault from the strobed monitor |
| gate_lo_in | input | 1 | Gate is below its low threshold |
| gate_hi_in | input | 1 | Gate drive has reached its high threshold |
| cb_trip_in | input | 1 | Circuit breaker comparator tripped |
| tmr_full_in | input | 1 | Overcurrent timer has reached its trip level |
| tmr_empty_in | input | 1 | Overcurrent timer discharged below its low level |
| gate_ramp | output | 1 | Enable the gate pull-up / charge pump |
| gate_pd | output | 1 | Enable the slow gate pull-down |
| status_ok | output | 1 | Power-good status (latched) |
| low_pwr | output | 1 | Block may run in its low-current mode |
| mode | output | 7 | One-hot operating mode |

## Verification
Some properties are checked on every clock: the mode stays one-hot, status is high only in normal-on or overcurrent, no gate ramp follows a low synchronized enable, current-fault mode never ramps, shutdown is entered only with the gate low, the latch-off build holds its fault, and the timer and low-time counters stay in range. Other behaviour can only be shown by the bench's scenarios. These are: the exact tick count of debounce and retry, the debounce restart after a strobed voltage fault, draining through debounce while the gate is still high, the difference between short and long enable-low pulses on a latched fault, and the different paths the two builds take after the same fault.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  localparam int MODE_W = 7;

  typedef enum logic [MODE_W-1:0] {
    M_SHDN  = 7'b0000001,
    M_DEB   = 7'b0000010,
    M_START = 7'b0000100,
    M_ON    = 7'b0001000,
    M_OC    = 7'b0010000,
    M_CF    = 7'b0100000,
    M_VF    = 7'b1000000
  } mode_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hs_low_meter.sv
module hs_low_meter #(
  parameter int MIN_CLKS = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic long_low
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || level) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign long_low = (cnt == LIM);

  // long-low may only be reported after the level was seen low
  assert_long_after_low_R9: assert property (@(posedge clk) disable iff (rst)
    long_low |-> $past(!level));
endmodule

// File: rtl/hs_ms_timer.sv
module hs_ms_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == (limit - CW'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr || done) cnt <= '0;
    else if (run && tick)   cnt <= cnt + 1'b1;
  end

  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hs_seq_pkg::*;
#(
  parameter int DEBOUNCE_MS = 40,
  parameter int RETRY_MS    = 500,
  parameter int EN_LOW_CLKS = 12500,
  parameter bit AUTO_RETRY  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       en_in,
  input  logic       uvlo_in,
  input  logic       vflt_in,
  input  logic       gate_lo_in,
  input  logic       gate_hi_in,
  input  logic       cb_trip_in,
  input  logic       tmr_full_in,
  input  logic       tmr_empty_in,
  output logic       gate_ramp,
  output logic       gate_pd,
  output logic       status_ok,
  output logic       low_pwr,
  output logic [6:0] mode
);
  localparam int MAXMS = (DEBOUNCE_MS > RETRY_MS) ? DEBOUNCE_MS : RETRY_MS;
  localparam int TCW   = $clog2(MAXMS + 1);
  localparam logic [TCW-1:0] DEB_L = TCW'(DEBOUNCE_MS);
  localparam logic [TCW-1:0] RET_L = TCW'(RETRY_MS);

  // synchronized asynchronous controls: bit0 enable, bit1 lockout
  logic [1:0] sy;
  logic en_s, uvlo_s;
  hs_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({uvlo_in, en_in}), .q(sy));
  assign en_s   = sy[0];
  assign uvlo_s = sy[1];

  logic en_long;
  hs_low_meter #(.MIN_CLKS(EN_LOW_CLKS)) u_low (
    .clk(clk), .rst(rst), .level(en_s), .long_low(en_long));

  mode_t mode_q, mode_n;
  logic  status_q, ramp_q, pd_q, lowp_q;
  logic  kill_off, cf_release, tm_run, tm_clr, tm_done;
  logic  on_n, status_n, ramp_n, lowp_n;

  assign kill_off   = !en_s || uvlo_s;
  assign cf_release = en_long || uvlo_s;

  assign tm_run = ((mode_q == M_DEB) && !vflt_in && !kill_off) ||
                  (AUTO_RETRY && (mode_q == M_CF) && tmr_empty_in &&
                   !cf_release && !vflt_in);
  assign tm_clr = (mode_n != mode_q) ||
                  ((mode_q == M_DEB) && (kill_off || vflt_in));

  hs_ms_timer #(.CW(TCW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tm_clr), .run(tm_run), .tick(ms_tick),
    .limit((mode_q == M_CF) ? RET_L : DEB_L), .done(tm_done));

  always_comb begin
    mode_n = mode_q;
    case (mode_q)
      M_SHDN: if (en_s && !uvlo_s) mode_n = M_DEB;
      M_DEB: begin
        if (kill_off) begin
          if (gate_lo_in) mode_n = M_SHDN;
        end else if (vflt_in) begin
          if (gate_lo_in) mode_n = M_VF;
        end else if (tm_done) mode_n = M_START;
      end
      M_START, M_ON, M_OC: begin
        if (kill_off || vflt_in)
          mode_n = gate_lo_in ? (kill_off ? M_SHDN : M_VF) : M_DEB;
        else if (tmr_full_in) mode_n = M_CF;
        else if (cb_trip_in)  mode_n = M_OC;
        else if ((mode_q == M_START) && gate_hi_in) mode_n = M_ON;
        else if (mode_q == M_OC) mode_n = status_q ? M_ON : M_START;
      end
      M_CF: begin
        if (cf_release) begin
          if (gate_lo_in) mode_n = M_SHDN;
        end else if (vflt_in) begin
          if (gate_lo_in) mode_n = M_VF;
        end else if (tm_done) mode_n = M_START;
      end
      M_VF: begin
        if (kill_off) begin
          if (gate_lo_in) mode_n = M_SHDN;
        end else if (!vflt_in) mode_n = M_DEB;
      end
      default: mode_n = M_SHDN;
    endcase
  end

  assign on_n     = (mode_n == M_START) || (mode_n == M_ON) || (mode_n == M_OC);
  assign ramp_n   = on_n && !kill_off && !vflt_in;
  assign status_n = !kill_off && !vflt_in &&
                    ((mode_n == M_ON) || ((mode_n == M_OC) && status_q));
  assign lowp_n   = !((mode_n == M_START) || (mode_n == M_OC) ||
                      ((mode_n == M_CF) && !tmr_empty_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_SHDN;
      status_q <= 1'b0;
      ramp_q   <= 1'b0;
      pd_q     <= 1'b1;
      lowp_q   <= 1'b1;
    end else begin
      mode_q   <= mode_n;
      status_q <= status_n;
      ramp_q   <= ramp_n;
      pd_q     <= !ramp_n;
      lowp_q   <= lowp_n;
    end
  end

  assign mode      = mode_q;
  assign status_ok = status_q;
  assign gate_ramp = ramp_q;
  assign gate_pd   = pd_q;
  assign low_pwr   = lowp_q;

  assert_mode_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_q) == 1);

  assert_status_in_on_modes_R5: assert property (@(posedge clk) disable iff (rst)
    status_q |-> ((mode_q == M_ON) || (mode_q == M_OC)));

  assert_no_ramp_after_disable_R6: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !ramp_q);

  assert_shdn_needs_gate_low_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SHDN) && ($past(mode_q) != M_SHDN)) |-> $past(gate_lo_in));

  assert_cf_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CF) |-> (!ramp_q && !status_q));

  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!AUTO_RETRY && (mode_q == M_CF) && !en_long && !uvlo_s)
      |=> ((mode_q == M_CF) || (mode_q == M_VF)));
endmodule

// File: tb/test_hotswap_seq.sv
module test_hotswap_seq;
  localparam int DEB = 40, RET = 500, ENLOW = 25, TDIV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic en_in = 0, uvlo_in = 1, vflt_in = 0, gate_lo_in = 1, gate_hi_in = 0;
  logic cb_in = 0, full_in = 0, empty_in = 1, tick = 0;
  logic [1:0] ramp_o, pd_o, st_o, lp_o;
  logic [6:0] mode_o [2];

  hotswap_seq #(.DEBOUNCE_MS(DEB), .RETRY_MS(RET), .EN_LOW_CLKS(ENLOW), .AUTO_RETRY(1'b0))
    i_hotswap_seq (
      .clk(clk), .rst(rst), .ms_tick(tick), .en_in(en_in), .uvlo_in(uvlo_in),
      .vflt_in(vflt_in), .gate_lo_in(gate_lo_in), .gate_hi_in(gate_hi_in),
      .cb_trip_in(cb_in), .tmr_full_in(full_in), .tmr_empty_in(empty_in),
      .gate_ramp(ramp_o[0]), .gate_pd(pd_o[0]), .status_ok(st_o[0]),
      .low_pwr(lp_o[0]), .mode(mode_o[0]));

  hotswap_seq #(.DEBOUNCE_MS(DEB), .RETRY_MS(RET), .EN_LOW_CLKS(ENLOW), .AUTO_RETRY(1'b1))
    i_hotswap_seq_ar (
      .clk(clk), .rst(rst), .ms_tick(tick), .en_in(en_in), .uvlo_in(uvlo_in),
      .vflt_in(vflt_in), .gate_lo_in(gate_lo_in), .gate_hi_in(gate_hi_in),
      .cb_trip_in(cb_in), .tmr_full_in(full_in), .tmr_empty_in(empty_in),
      .gate_ramp(ramp_o[1]), .gate_pd(pd_o[1]), .status_ok(st_o[1]),
      .low_pwr(lp_o[1]), .mode(mode_o[1]));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 1 ms tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  // behavioural reference model; modes as bit index 0..6
  int md [2], tc [2], lowc;
  bit mst [2], mrp [2], mpd [2], mlp [2];
  bit s_en1, s_en2, s_uv1, s_uv2;
  int cur, nx;
  bit e_s, u_s, lng, koff, krel, ok_pwr;

  always @(posedge clk) begin
    if (rst) begin
      s_en1 = 0; s_en2 = 0; s_uv1 = 1; s_uv2 = 1; lowc = 0;
      for (int k = 0; k < 2; k++) begin
        md[k] = 0; tc[k] = 0; mst[k] = 0; mrp[k] = 0; mpd[k] = 1; mlp[k] = 1;
      end
    end else begin
      e_s = s_en2; u_s = s_uv2; lng = (lowc == ENLOW);
      koff = !e_s || u_s; krel = lng || u_s; ok_pwr = !koff && !vflt_in;
      for (int k = 0; k < 2; k++) begin
        cur = md[k]; nx = cur;
        case (cur)
          0: if (e_s && !u_s) nx = 1;
          1: if (koff || vflt_in) begin
               tc[k] = 0;
               if (gate_lo_in) nx = koff ? 0 : 6;
             end else if (tick) begin
               if (tc[k] == DEB - 1) nx = 2; else tc[k]++;
             end
          2, 3, 4: if (koff || vflt_in) nx = gate_lo_in ? (koff ? 0 : 6) : 1;
             else if (full_in) nx = 5;
             else if (cb_in) nx = 4;
             else if (cur == 2 && gate_hi_in) nx = 3;
             else if (cur == 4) nx = mst[k] ? 3 : 2;
          5: if (krel) begin
               if (gate_lo_in) nx = 0;
             end else if (vflt_in) begin
               if (gate_lo_in) nx = 6;
             end else if (k == 1 && empty_in && tick) begin
               if (tc[k] == RET - 1) nx = 2; else tc[k]++;
             end
          default: if (koff) begin
               if (gate_lo_in) nx = 0;
             end else if (!vflt_in) nx = 1;
        endcase
        if (nx != cur) tc[k] = 0;
        mrp[k] = ok_pwr && (nx == 2 || nx == 3 || nx == 4);
        mpd[k] = !mrp[k];
        mst[k] = ok_pwr && (nx == 3 || (nx == 4 && mst[k]));
        mlp[k] = !(nx == 2 || nx == 4 || (nx == 5 && !empty_in));
        md[k] = nx;
      end
      if (e_s) lowc = 0; else if (lowc < ENLOW) lowc++;
      s_en2 = s_en1; s_en1 = en_in; s_uv2 = s_uv1; s_uv1 = uvlo_in;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        chk(int'(mode_o[k]) == (1 << md[k]), "R2", "model mode", int'(mode_o[k]), 1 << md[k]);
        chk(ramp_o[k] == mrp[k], "R6", "model gate_ramp", int'(ramp_o[k]), int'(mrp[k]));
        chk(pd_o[k] == mpd[k], "R6", "model gate_pd", int'(pd_o[k]), int'(mpd[k]));
        chk(st_o[k] == mst[k], "R5", "model status", int'(st_o[k]), int'(mst[k]));
        chk(lp_o[k] == mlp[k], "R11", "model low_pwr", int'(lp_o[k]), int'(mlp[k]));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(input int k, input int m, input int maxc, output int n);
    n = 0;
    while (mode_o[k] != 7'(1 << m) && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic chk_mode(input int k, input int m, input string req);
    chk(mode_o[k] == 7'(1 << m), req, $sformatf("mode inst%0d", k),
        int'(mode_o[k]), 1 << m);
  endtask

  initial begin
    int n;
    cyc(4);
    for (int k = 0; k < 2; k++) begin
      chk_mode(k, 0, "R1");
      chk(ramp_o[k] == 0 && pd_o[k] == 1, "R1", "gate drive", int'({ramp_o[k], pd_o[k]}), 1);
      chk(st_o[k] == 0 && lp_o[k] == 1, "R1", "status/low_pwr", int'({st_o[k], lp_o[k]}), 1);
    end
    rst = 0;
    cyc(1);
    // R12: two synchronizer flops then the mode register
    uvlo_in = 0; en_in = 1;
    cyc(2); chk_mode(0, 0, "R12");
    cyc(1); chk_mode(0, 1, "R12"); chk_mode(1, 1, "R3");
    // R4: voltage fault mid-debounce restarts the count
    cyc(150); chk_mode(0, 1, "R3");
    vflt_in = 1; cyc(1); chk_mode(0, 6, "R4");
    cyc(30); vflt_in = 0; cyc(1); chk_mode(0, 1, "R4");
    wait_mode(0, 2, 600, n);
    chk(n >= 391 && n <= 400, "R3", "debounce cycles", n, 400);
    chk_mode(1, 2, "R3");
    // start-up -> normal-on
    gate_lo_in = 0; cyc(2);
    chk(lp_o[0] == 0 && ramp_o[0] == 1, "R11", "start-up power", int'({lp_o[0], ramp_o[0]}), 1);
    gate_hi_in = 1; cyc(1);
    chk_mode(0, 3, "R5"); chk(st_o[0] == 1, "R5", "status latched", int'(st_o[0]), 1);
    // R7: overcurrent from normal-on keeps status
    cb_in = 1; cyc(1); chk_mode(0, 4, "R7");
    chk(st_o[0] == 1 && lp_o[0] == 0, "R5", "status in OC", int'({st_o[0], lp_o[0]}), 2);
    cb_in = 0; cyc(1); chk_mode(0, 3, "R7");
    // R6: short enable drop with gate still high drains in debounce
    en_in = 0; cyc(4);
    chk_mode(0, 1, "R6");
    chk(ramp_o[0] == 0 && st_o[0] == 0, "R6", "off drive", int'({ramp_o[0], st_o[0]}), 0);
    cyc(6); en_in = 1; cyc(5);
    chk_mode(0, 1, "R6"); chk(st_o[0] == 0, "R5", "status not relatched", int'(st_o[0]), 0);
    gate_hi_in = 0; gate_lo_in = 1;
    wait_mode(0, 2, 600, n);
    gate_lo_in = 0; gate_hi_in = 1; cyc(1); chk_mode(0, 3, "R5");
    // R6: voltage fault with gate high, then gate low -> voltage-fault mode
    vflt_in = 1; cyc(1); chk_mode(0, 1, "R6");
    chk(ramp_o[0] == 0, "R6", "ramp off on vfault", int'(ramp_o[0]), 0);
    gate_hi_in = 0; gate_lo_in = 1; cyc(1); chk_mode(0, 6, "R6");
    vflt_in = 0; cyc(1); chk_mode(0, 1, "R4");
    wait_mode(0, 2, 600, n);
    // R5/R8/R11: overcurrent from start-up, then timer trips
    cb_in = 1; cyc(1); chk_mode(0, 4, "R7");
    chk(st_o[0] == 0, "R5", "status in OC from start-up", int'(st_o[0]), 0);
    full_in = 1; empty_in = 0; cyc(1);
    for (int k = 0; k < 2; k++) begin
      chk_mode(k, 5, "R8");
      chk(ramp_o[k] == 0 && lp_o[k] == 0, "R11", "CF draining", int'({ramp_o[k], lp_o[k]}), 0);
    end
    full_in = 0; cb_in = 0; cyc(20);
    empty_in = 1; cyc(1);
    chk(lp_o[0] == 1, "R11", "CF timer empty", int'(lp_o[0]), 1);
    // R10: auto-retry after RET ticks
    wait_mode(1, 2, 6000, n);
    chk(n >= 4980 && n <= 5000, "R10", "retry cycles", n, 5000);
    chk_mode(0, 5, "R9");
    // R9: short enable-low pulse keeps the latch
    en_in = 0; cyc(10); en_in = 1; cyc(5);
    chk_mode(0, 5, "R9");
    // R9: long enable-low pulse clears it
    en_in = 0; cyc(40); chk_mode(0, 0, "R9");
    en_in = 1;
    wait_mode(0, 2, 600, n); chk_mode(1, 2, "R3");
    // R9: voltage fault clears the latch in both builds
    full_in = 1; empty_in = 0; cyc(1); chk_mode(0, 5, "R8");
    full_in = 0; vflt_in = 1; cyc(1);
    chk_mode(0, 6, "R9"); chk_mode(1, 6, "R9");
    vflt_in = 0; empty_in = 1; cyc(1); chk_mode(0, 1, "R4");
    // R12: lockout takes effect after synchronizer
    uvlo_in = 1; cyc(3); chk_mode(0, 0, "R12"); chk_mode(1, 0, "R12");
    cyc(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule